// File: doc/BRIEF.md
# Sequential Booth Signed Multiplier

This block multiplies two signed two's-complement operands using radix-2 Booth recoding. It handles one multiplier bit per clock cycle. A pulse on `start` while the block is idle captures both operands. For `WIDTH` cycles the block then looks at the lowest multiplier bit together with a guard bit below it. From that pair it decides to add the multiplicand to the running accumulator, subtract it, or leave the accumulator alone. After that decision it shifts the whole accumulator/multiplier/guard chain right by one place, arithmetically.

When the last step has been taken, `done` goes high for one cycle. The double-width signed product then stands on `product` and stays there until the next accepted start. Negative multipliers, negative multiplicands and the most negative multiplicand all give exact results. The accumulator carries one bit of headroom above the operand width, so the subtraction can never wrap.

Top module: `booth_seq_mult`

## Requirements
- R1: While reset is asserted, and after it, `busy`, `done` and `product` are all zero until the first accepted start.
- R2: A start accepted at a clock edge makes `busy` high for exactly `WIDTH` cycles. `done` is high in the cycle that follows the `WIDTH`-th edge after the accepting edge.
- R3: When `done` is high, `product` equals the signed product of the captured operands as a `2*WIDTH`-bit two's-complement value.
- R4: Negative multipliers, negative multiplicands and the most negative value of either operand (bit `WIDTH-1` set, all other bits zero) give exact products. This includes most-negative times most-negative, which is 2^(2*WIDTH-2).
- R5: `start` and operand changes while `busy` is high have no effect. The running operation keeps its operands and its length.
- R6: While the block is idle and `start` is low, `product` holds its value.
- R7: `done` is high for a single cycle per operation, and never while `busy` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begin an operation; taken only when idle |
| multiplicand | input | WIDTH | Signed multiplicand, sampled on accepted start |
| multiplier | input | WIDTH | Signed multiplier, sampled on accepted start |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| product | output | 2*WIDTH | Signed product |

## Verification
The checker treats the operands as meaningful only in the cycle where `start` is accepted while idle. Its reference product is built from the values captured in that cycle, so later operand changes must not matter. It also takes for granted that reset is the only thing that aborts an operation, and that the inputs are never unknown. The bench keeps to these assumptions. It drives every input away from the clock edge and always gives fully defined operands. On purpose, it changes `start` and both operands in the middle of an operation, which exercises the case where they must be ignored.

// File: rtl/booth_pkg.sv
package booth_pkg;
    typedef enum logic [1:0] {
        STEP_KEEP = 2'd0,
        STEP_ADD  = 2'd1,
        STEP_SUB  = 2'd2
    } step_op_e;
endpackage

// File: rtl/booth_recode.sv
module booth_recode
    import booth_pkg::*;
(
    input  logic     low_bit,
    input  logic     guard_bit,
    output step_op_e op
);
    always_comb begin
        unique case ({low_bit, guard_bit})
            2'b10:   op = STEP_SUB;
            2'b01:   op = STEP_ADD;
            default: op = STEP_KEEP;
        endcase
    end
endmodule

// File: rtl/booth_addsub.sv
module booth_addsub
    import booth_pkg::*;
#(
    parameter int WIDTH = 32
) (
    input  logic [WIDTH:0]   acc_in,
    input  logic [WIDTH-1:0] mcand,
    input  step_op_e         op,
    output logic [WIDTH:0]   acc_out
);
    logic [WIDTH:0] mcand_ext;

    assign mcand_ext = {mcand[WIDTH-1], mcand};

    always_comb begin
        unique case (op)
            STEP_ADD: acc_out = acc_in + mcand_ext;
            STEP_SUB: acc_out = acc_in - mcand_ext;
            default:  acc_out = acc_in;
        endcase
    end
endmodule

// File: rtl/booth_shift.sv
module booth_shift #(
    parameter int WIDTH = 32
) (
    input  logic [WIDTH:0]   acc_in,
    input  logic [WIDTH-1:0] q_in,
    output logic [WIDTH:0]   acc_out,
    output logic [WIDTH-1:0] q_out,
    output logic             guard_out
);
    assign acc_out   = {acc_in[WIDTH], acc_in[WIDTH:1]};
    assign q_out     = {acc_in[0], q_in[WIDTH-1:1]};
    assign guard_out = q_in[0];
endmodule

// File: rtl/booth_seq_mult.sv
module booth_seq_mult
    import booth_pkg::*;
#(
    parameter int WIDTH = 32
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 start,
    input  logic [WIDTH-1:0]     multiplicand,
    input  logic [WIDTH-1:0]     multiplier,
    output logic                 busy,
    output logic                 done,
    output logic [2*WIDTH-1:0]   product
);
    localparam int CW = $clog2(WIDTH + 1);

    typedef struct packed {
        logic             busy;
        logic             done;
        logic [CW-1:0]    cnt;
        logic [WIDTH:0]   acc;
        logic [WIDTH-1:0] q;
        logic             guard;
        logic [WIDTH-1:0] mcand;
    } mul_state_t;

    mul_state_t s_q, s_d;

    step_op_e         op_w;
    logic [WIDTH:0]   sum_w;
    logic [WIDTH:0]   sh_acc_w;
    logic [WIDTH-1:0] sh_q_w;
    logic             sh_guard_w;

    booth_recode u_recode (
        .low_bit   (s_q.q[0]),
        .guard_bit (s_q.guard),
        .op        (op_w)
    );

    booth_addsub #(.WIDTH(WIDTH)) u_addsub (
        .acc_in  (s_q.acc),
        .mcand   (s_q.mcand),
        .op      (op_w),
        .acc_out (sum_w)
    );

    booth_shift #(.WIDTH(WIDTH)) u_shift (
        .acc_in    (sum_w),
        .q_in      (s_q.q),
        .acc_out   (sh_acc_w),
        .q_out     (sh_q_w),
        .guard_out (sh_guard_w)
    );

    always_comb begin
        s_d      = s_q;
        s_d.done = 1'b0;
        if (!s_q.busy) begin
            if (start) begin
                s_d.busy  = 1'b1;
                s_d.cnt   = CW'(WIDTH);
                s_d.acc   = '0;
                s_d.q     = multiplier;
                s_d.guard = 1'b0;
                s_d.mcand = multiplicand;
            end
        end else begin
            s_d.acc   = sh_acc_w;
            s_d.q     = sh_q_w;
            s_d.guard = sh_guard_w;
            s_d.cnt   = s_q.cnt - CW'(1);
            if (s_q.cnt == CW'(1)) begin
                s_d.busy = 1'b0;
                s_d.done = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign busy    = s_q.busy;
    assign done    = s_q.done;
    assign product = {s_q.acc[WIDTH-1:0], s_q.q};
endmodule

// File: rtl/booth_seq_mult_chk.sv
module booth_seq_mult_chk #(
    parameter int WIDTH = 32
) (
    input logic               clk,
    input logic               rst_n,
    input logic               start,
    input logic [WIDTH-1:0]   multiplicand,
    input logic [WIDTH-1:0]   multiplier,
    input logic               busy,
    input logic               done,
    input logic [2*WIDTH-1:0] product
);
    localparam int CW = $clog2(WIDTH + 2);

    logic [WIDTH-1:0] cap_a_q, cap_b_q;
    logic [CW-1:0]    run_cnt_q;
    logic signed [2*WIDTH-1:0] ref_prod;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cap_a_q   <= '0;
            cap_b_q   <= '0;
            run_cnt_q <= '0;
        end else if (start && !busy) begin
            cap_a_q   <= multiplicand;
            cap_b_q   <= multiplier;
            run_cnt_q <= '0;
        end else if (busy) begin
            run_cnt_q <= run_cnt_q + CW'(1);
        end
    end

    assign ref_prod = $signed({{WIDTH{cap_a_q[WIDTH-1]}}, cap_a_q})
                    * $signed({{WIDTH{cap_b_q[WIDTH-1]}}, cap_b_q});

    assert_reset_clear_R1: assert property (@(posedge clk)
        !rst_n |=> (!busy && !done));

    assert_run_length_R2: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (run_cnt_q == CW'(WIDTH)));

    assert_product_ok_R3: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (product == ref_prod));

    assert_start_ignored_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && start) |=> (busy || done));

    assert_product_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !start) |=> $stable(product));

    assert_done_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    assert_done_not_busy_R7: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);
endmodule

bind booth_seq_mult booth_seq_mult_chk #(.WIDTH(WIDTH)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .start        (start),
    .multiplicand (multiplicand),
    .multiplier   (multiplier),
    .busy         (busy),
    .done         (done),
    .product      (product)
);

// File: tb/sim_booth_seq_mult.sv
`timescale 1ns/1ps
module sim_booth_seq_mult;
    localparam int W  = 32;
    localparam int NV = 10;

    localparam logic [W-1:0] VEC_A [NV] = '{
        32'd7, 32'hFFFF_FFF9, 32'd7, 32'hFFFF_FFFB, 32'h8000_0000,
        32'h8000_0000, 32'h7FFF_FFFF, 32'h1234_5678, 32'h8000_0000, 32'hAAAA_AAAA
    };
    localparam logic [W-1:0] VEC_B [NV] = '{
        32'd3, 32'd3, 32'hFFFF_FFFD, 32'hFFFF_FFFD, 32'd7,
        32'h8000_0000, 32'h7FFF_FFFF, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'h5555_5555
    };

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             start = 1'b0;
    logic [W-1:0]     a = '0;
    logic [W-1:0]     b = '0;
    logic             busy, done;
    logic [2*W-1:0]   product;

    int total = 0;
    int bad   = 0;

    always #4 clk = ~clk;

    booth_seq_mult #(.WIDTH(W)) u0 (
        .clk(clk), .rst_n(rst_n), .start(start),
        .multiplicand(a), .multiplier(b),
        .busy(busy), .done(done), .product(product)
    );

    function automatic logic [2*W-1:0] ref_mul(input logic [W-1:0] x, input logic [W-1:0] y);
        return $signed({{W{x[W-1]}}, x}) * $signed({{W{y[W-1]}}, y});
    endfunction

    task automatic chk(input bit ok, input string req, input logic [2*W-1:0] act, input logic [2*W-1:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic run_op(input logic [W-1:0] x, input logic [W-1:0] y,
                          output logic [2*W-1:0] res, output int lat);
        a = x; b = y; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        lat = 1;
        while (!done && lat < 200) begin
            @(negedge clk);
            lat++;
        end
        res = product;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        bad++;
        total++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [2*W-1:0] res, held;
        int lat;
        repeat (3) @(negedge clk);
        chk(!busy && !done && product == '0, "R1 in reset", {busy, done, product[61:0]}, '0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!busy && !done && product == '0, "R1 after reset", {busy, done, product[61:0]}, '0);

        for (int i = 0; i < NV; i++) begin
            run_op(VEC_A[i], VEC_B[i], res, lat);
            chk(res == ref_mul(VEC_A[i], VEC_B[i]), (i >= 4) ? "R4 extreme operand" : "R3 signed product",
                res, ref_mul(VEC_A[i], VEC_B[i]));
            chk(lat == W + 1, "R2 latency", 64'(lat), 64'(W + 1));
            @(negedge clk);
            chk(!done, "R7 done single cycle", {63'd0, done}, '0);
        end

        // R6: product held while idle
        held = product;
        a = 32'h1111_1111; b = 32'h2222_2222;
        repeat (5) @(negedge clk);
        chk(product == held && !busy, "R6 hold while idle", product, held);

        // R5: start and operands changed mid-run
        a = 32'd3; b = 32'hFFFF_FFFB; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        repeat (5) @(negedge clk);
        a = 32'd100; b = 32'd100; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        lat = 7;
        while (!done && lat < 200) begin
            @(negedge clk);
            lat++;
        end
        chk(product == 64'hFFFF_FFFF_FFFF_FFF1, "R5 result unchanged", product, 64'hFFFF_FFFF_FFFF_FFF1);
        chk(lat == W + 1, "R5 length unchanged", 64'(lat), 64'(W + 1));
        chk(!busy, "R7 not busy with done", {63'd0, busy}, '0);

        // R1: reset during an operation
        a = 32'd9; b = 32'd9; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        repeat (4) @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        chk(!busy && !done && product == '0, "R1 reset mid-run", product, '0);
        rst_n = 1'b1;
        @(negedge clk);
        run_op(32'd7, 32'd3, res, lat);
        chk(res == 64'd21, "R3 after reset", res, 64'd21);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule